// File: doc/BRIEF.md
# Serial Channel Control Register File

This block is the per-channel register state of a serial communications controller. It sits behind the register access front end: the front end resolves a register number and presents it with a write or read strobe. The block stores sixteen 8-bit control registers and one enhancement shadow byte. It also keeps four status registers. Several control writes have side effects and follow masked update rules rather than plain storage. The block pulls the clock-recovery PLL and baud generator state out of control register 14 and exposes it as registered outputs for the timing logic downstream.

Two synchronous reset commands are supported. The hardware reset and the channel reset each apply masks to the current register contents. The two commands differ in how they treat registers 10, 11 and 14. The asynchronous reset `rst_n` leaves the block in the same state as a hardware reset applied to all-zero registers. Receive-character-available status is set from a receive-data-valid input when status register 0 is read. A receive-data pop strobe clears it.

Top module: `sccr_chan_regs`

## Requirements
- R1: A hardware reset command (`hw_rst_req`) sets control register 10 to 0x00, register 11 to 0x08 and register 14 to (reg14 & 0xC0) | 0x20. It applies the masks shared with channel reset: reg1 &= 0x24, reg3 &= 0xFE, reg4 |= 0x04, reg5 &= 0x61, reg15 = 0xF8. Other registers keep their values. `rst_n` gives the hardware-reset values of all-zero registers (reg4=0x04, reg11=0x08, reg14=0x20, reg15=0xF8, rest 0).
- R2: A channel reset command (`ch_rst_req`, lower priority than `hw_rst_req`) applies the shared masks. It sets reg10 to reg10 & 0x60 and reg14 to (reg14 & 0xC3) | 0x20, and leaves reg11 unchanged.
- R3: Either reset command sets status 0 to (status0 & 0x38) | 0x44, status 1 to 0x06, and status 3 and status 10 to 0x00. It also clears `rx_en`, `pll_active` and `brg_en`. A reset command has priority over a write in the same cycle.
- R4: A write to control register 3 whose bit 4 differs from the stored bit 4 sets stored bit 4 and status 0 bit 4. A write never clears stored bit 4.
- R5: A write to control register 3 stores bit 0 (receiver enable, driven on `rx_en`) and bits 7:5 and 3:1 as written. If the write takes bit 0 from 1 to 0, it also sets stored bit 4 and status 0 bit 4.
- R6: A write to control register 7 while control register 15 bit 0 is 1 updates only the shadow byte (`enh_sync`) and leaves register 7 unchanged. Otherwise it updates register 7.
- R7: A write to control register 14 runs the PLL command in bits 7:5: 0 none; 1 sets `pll_active`; 2 no state change; 3 clears `pll_active` and `pll_src_pin`; 4 clears `pll_src_pin`; 5 sets `pll_src_pin`; 6 sets `pll_fm`; 7 clears `pll_fm`.
- R8: Every write to control register 14 copies its bit 0 to `brg_en`.
- R9: A write to control register 14 with any of bits 4, 3, 2 set raises `cfg_warn` for exactly the following cycle.
- R10: Status 0 bit 0 is set by a status 0 read (`rd_en`, `rd_ctl`=0, `addr`=0) while `rx_avail` is 1, and cleared by `rx_pop` (pop wins). `rdata` for status 0 shows bit 0 as stored bit 0 OR `rx_avail`.
- R11: Control writes not covered by R4 to R8 store the full byte. With `rd_ctl`=1, `rdata` returns control register `addr`. With `rd_ctl`=0 it returns status 0, 1, 3 or 10 at those addresses and 0x00 elsewhere.
- R12: `pll_miss_in[1:0]` sets status 10 bits 7:6. PLL commands 1 and 2 clear them, and the clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hw_rst_req | input | 1 | Hardware reset command (one cycle) |
| ch_rst_req | input | 1 | Channel reset command (one cycle) |
| wr_en | input | 1 | Control register write strobe |
| rd_en | input | 1 | Read strobe (side effects on status 0) |
| rd_ctl | input | 1 | Read bank select: 1 control registers, 0 status registers |
| addr | input | 4 | Register number |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` / `rd_ctl` |
| rx_avail | input | 1 | Receive data valid |
| rx_pop | input | 1 | Receive data register has been read |
| pll_miss_in | input | 2 | Missing-clock flags raised by PLL logic |
| rx_en | output | 1 | Receiver enable |
| pll_active | output | 1 | PLL running |
| pll_src_pin | output | 1 | PLL clock source: 1 pin, 0 baud generator |
| pll_fm | output | 1 | PLL mode: 1 FM, 0 NRZI |
| brg_en | output | 1 | Baud generator enable |
| enh_sync | output | 8 | Enhancement shadow byte |
| cfg_warn | output | 1 | Unsupported loopback/echo/request bits written |

## Verification
A wrong mask in the reset logic appears in `rdata` on the first control read after the reset command's clock edge. A lost or duplicated side effect of register 3 appears the same way on `rx_en` or on status 0 bit 4, one cycle after the write. Register 14 command decoding shows on the PLL and baud outputs in the cycle right after the write. A misrouted shadow write shows as either a changed register 7 or an unchanged `enh_sync`. Receive-available errors show as a wrong status 0 bit 0 on the read after the triggering read or pop.

// File: rtl/sccr_pkg.sv
package sccr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

  typedef logic [ADDR_W-1:0] reg_idx_t;
  typedef logic [DATA_W-1:0] byte_t;

  // control register numbers with special handling
  localparam reg_idx_t C_INTMODE = 4'd1;
  localparam reg_idx_t C_RXCFG   = 4'd3;
  localparam reg_idx_t C_RXMISC  = 4'd4;
  localparam reg_idx_t C_TXCFG   = 4'd5;
  localparam reg_idx_t C_SYNC2   = 4'd7;
  localparam reg_idx_t C_CODING  = 4'd10;
  localparam reg_idx_t C_CLKSEL  = 4'd11;
  localparam reg_idx_t C_MISC    = 4'd14;
  localparam reg_idx_t C_EXTIE   = 4'd15;

  // status register numbers
  localparam reg_idx_t S_MAIN = 4'd0;
  localparam reg_idx_t S_COND = 4'd1;
  localparam reg_idx_t S_IRQ  = 4'd3;
  localparam reg_idx_t S_LOOP = 4'd10;

  typedef enum logic [2:0] {
    PLL_NOP      = 3'd0,
    PLL_SEARCH   = 3'd1,
    PLL_CLR_MISS = 3'd2,
    PLL_OFF      = 3'd3,
    PLL_SRC_BRG  = 3'd4,
    PLL_SRC_PIN  = 3'd5,
    PLL_MODE_FM  = 3'd6,
    PLL_MODE_NRZ = 3'd7
  } pll_cmd_e;

  // value a control register takes on a reset command
  function automatic byte_t ctl_soft_val(input reg_idx_t idx, input byte_t cur, input logic hw);
    byte_t v;
    v = cur;
    case (idx)
      C_INTMODE: v = cur & 8'h24;
      C_RXCFG:   v = cur & 8'hFE;
      C_RXMISC:  v = cur | 8'h04;
      C_TXCFG:   v = cur & 8'h61;
      C_CODING:  v = hw ? 8'h00 : (cur & 8'h60);
      C_CLKSEL:  v = hw ? 8'h08 : cur;
      C_MISC:    v = (cur & (hw ? 8'hC0 : 8'hC3)) | 8'h20;
      C_EXTIE:   v = 8'hF8;
      default:   v = cur;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sccr_ctl_bank.sv
module sccr_ctl_bank
  import sccr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hw_rst,
  input  logic                       soft_rst,
  input  logic                       wr_en,
  input  reg_idx_t                   addr,
  input  byte_t                      wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] ctl_q,
  output byte_t                      enh_q,
  output logic                       hunt_evt
);
  logic [NUM_REGS-1:0][DATA_W-1:0] ctl_d;
  logic [NUM_REGS-1:0]             ctl_en;
  byte_t enh_d;
  logic  enh_en;
  logic  wr_ok, wr_rxcfg, hunt_diff, rx_off;
  byte_t rx_cur;

  assign wr_ok     = wr_en & ~soft_rst;
  assign wr_rxcfg  = wr_ok & (addr == C_RXCFG);
  assign rx_cur    = ctl_q[C_RXCFG];
  assign hunt_diff = wdata[4] ^ rx_cur[4];
  assign rx_off    = rx_cur[0] & ~wdata[0];
  assign hunt_evt  = wr_rxcfg & (hunt_diff | rx_off);
  assign enh_en    = wr_ok & (addr == C_SYNC2) & ctl_q[C_EXTIE][0];
  assign enh_d     = wdata;

  always_comb begin
    ctl_d = ctl_q;
    if (soft_rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        ctl_d[i] = ctl_soft_val(ADDR_W'(i), ctl_q[i], hw_rst);
    end else if (wr_en) begin
      if (addr == C_RXCFG)
        ctl_d[C_RXCFG] = {wdata[7:5], rx_cur[4] | hunt_diff | rx_off, wdata[3:1], wdata[0]};
      else if (addr == C_SYNC2 && ctl_q[C_EXTIE][0])
        ctl_d[C_SYNC2] = ctl_q[C_SYNC2];
      else
        ctl_d[addr] = wdata;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam byte_t POR = ctl_soft_val(ADDR_W'(g), 8'h00, 1'b1);
    assign ctl_en[g] = soft_rst | (wr_en & (addr == ADDR_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctl_q[g] <= POR;
      else if (ctl_en[g]) ctl_q[g] <= ctl_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enh_q <= '0;
    else if (enh_en) enh_q <= enh_d;
  end

  p_hunt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[C_RXCFG][4] |=> ctl_q[C_RXCFG][4]);
  p_rst_ctl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl_q[C_EXTIE] == 8'hF8) && ctl_q[C_MISC][5] && !ctl_q[C_RXCFG][0]);
  p_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && addr == C_SYNC2 && ctl_q[C_EXTIE][0]) |=> $stable(ctl_q[C_SYNC2]));
endmodule

// File: rtl/sccr_pll_cmd.sv
module sccr_pll_cmd
  import sccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cmd_wr,
  input  logic [2:0] cmd_code,
  input  logic [2:0] cmd_loop,
  input  logic       cmd_brg,
  output logic       pll_active,
  output logic       pll_src_pin,
  output logic       pll_fm,
  output logic       brg_en,
  output logic       cfg_warn,
  output logic       miss_clr
);
  logic act_d, src_d, fm_d, brg_d, warn_d, cmd_ok;
  pll_cmd_e cmd;

  assign cmd_ok   = cmd_wr & ~soft_rst;
  assign cmd      = pll_cmd_e'(cmd_code);
  assign miss_clr = cmd_ok & ((cmd == PLL_SEARCH) | (cmd == PLL_CLR_MISS));
  assign warn_d   = cmd_ok & (|cmd_loop);

  always_comb begin
    act_d = pll_active;
    src_d = pll_src_pin;
    fm_d  = pll_fm;
    brg_d = brg_en;
    if (soft_rst) begin
      act_d = 1'b0;
      brg_d = 1'b0;
    end else if (cmd_wr) begin
      brg_d = cmd_brg;
      case (cmd)
        PLL_SEARCH:   act_d = 1'b1;
        PLL_OFF:      begin act_d = 1'b0; src_d = 1'b0; end
        PLL_SRC_BRG:  src_d = 1'b0;
        PLL_SRC_PIN:  src_d = 1'b1;
        PLL_MODE_FM:  fm_d  = 1'b1;
        PLL_MODE_NRZ: fm_d  = 1'b0;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_active  <= 1'b0;
      pll_src_pin <= 1'b0;
      pll_fm      <= 1'b0;
      brg_en      <= 1'b0;
      cfg_warn    <= 1'b0;
    end else begin
      pll_active  <= act_d;
      pll_src_pin <= src_d;
      pll_fm      <= fm_d;
      brg_en      <= brg_d;
      cfg_warn    <= warn_d;
    end
  end

  p_off_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !soft_rst && cmd_code == 3'd3) |=> (!pll_active && !pll_src_pin));
  p_brg_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !soft_rst) |=> (brg_en == $past(cmd_brg)));
  p_warn_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_warn |-> $past(cmd_wr));
endmodule

// File: rtl/sccr_sts_bank.sv
module sccr_sts_bank
  import sccr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       rx_avail,
  input  logic       st_main_rd,
  input  logic       rx_pop,
  input  logic       hunt_set,
  input  logic       miss_clr,
  input  logic [1:0] miss_in,
  output byte_t      st_main,
  output byte_t      st_cond,
  output byte_t      st_irq,
  output byte_t      st_loop
);
  byte_t main_d, cond_d, irq_d, loop_d;

  always_comb begin
    main_d = st_main;
    cond_d = st_cond;
    irq_d  = st_irq;
    loop_d = st_loop;
    if (soft_rst) begin
      main_d = (st_main & 8'h38) | 8'h44;
      cond_d = 8'h06;
      irq_d  = 8'h00;
      loop_d = 8'h00;
    end else begin
      if (hunt_set)               main_d[4] = 1'b1;
      if (st_main_rd && rx_avail) main_d[0] = 1'b1;
      if (rx_pop)                 main_d[0] = 1'b0;
      loop_d[7:6] = st_loop[7:6] | miss_in;
      if (miss_clr)               loop_d[7:6] = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_main <= 8'h44;
      st_cond <= 8'h06;
      st_irq  <= 8'h00;
      st_loop <= 8'h00;
    end else begin
      st_main <= main_d;
      st_cond <= cond_d;
      st_irq  <= irq_d;
      st_loop <= loop_d;
    end
  end

  p_pop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> !st_main[0]);
  p_clr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    miss_clr |=> (st_loop[7:6] == 2'b00));
  p_rst_sts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_cond == 8'h06) && (st_irq == 8'h00) && st_main[2] && st_main[6] && !st_main[0]);
endmodule

// File: rtl/sccr_chan_regs.sv
module sccr_chan_regs
  import sccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_req,
  input  logic              ch_rst_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              rd_ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_avail,
  input  logic              rx_pop,
  input  logic [1:0]        pll_miss_in,
  output logic              rx_en,
  output logic              pll_active,
  output logic              pll_src_pin,
  output logic              pll_fm,
  output logic              brg_en,
  output logic [DATA_W-1:0] enh_sync,
  output logic              cfg_warn
);
  logic [NUM_REGS-1:0][DATA_W-1:0] ctl_q;
  logic  soft_rst, hunt_evt, miss_clr, st_main_rd, misc_wr;
  byte_t st_main, st_cond, st_irq, st_loop;

  assign soft_rst   = hw_rst_req | ch_rst_req;
  assign st_main_rd = rd_en & ~rd_ctl & (addr == S_MAIN);
  assign misc_wr    = wr_en & (addr == C_MISC);
  assign rx_en      = ctl_q[C_RXCFG][0];

  sccr_ctl_bank u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_rst   (hw_rst_req),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .ctl_q    (ctl_q),
    .enh_q    (enh_sync),
    .hunt_evt (hunt_evt)
  );

  sccr_pll_cmd u_pll (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cmd_wr      (misc_wr),
    .cmd_code    (wdata[7:5]),
    .cmd_loop    (wdata[4:2]),
    .cmd_brg     (wdata[0]),
    .pll_active  (pll_active),
    .pll_src_pin (pll_src_pin),
    .pll_fm      (pll_fm),
    .brg_en      (brg_en),
    .cfg_warn    (cfg_warn),
    .miss_clr    (miss_clr)
  );

  sccr_sts_bank u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rx_avail   (rx_avail),
    .st_main_rd (st_main_rd),
    .rx_pop     (rx_pop),
    .hunt_set   (hunt_evt),
    .miss_clr   (miss_clr),
    .miss_in    (pll_miss_in),
    .st_main    (st_main),
    .st_cond    (st_cond),
    .st_irq     (st_irq),
    .st_loop    (st_loop)
  );

  always_comb begin
    rdata = '0;
    if (rd_ctl) begin
      rdata = ctl_q[addr];
    end else begin
      case (addr)
        S_MAIN:  rdata = {st_main[7:1], st_main[0] | rx_avail};
        S_COND:  rdata = st_cond;
        S_IRQ:   rdata = st_irq;
        S_LOOP:  rdata = st_loop;
        default: rdata = '0;
      endcase
    end
  end

  p_hunt_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && addr == C_RXCFG && rx_en && !wdata[0]) |=> (st_main[4] && !rx_en));
endmodule

// File: tb/test_sccr_chan_regs.sv
`timescale 1ns/1ps
module test_sccr_chan_regs;
  logic       clk = 1'b0;
  logic       rst_n, hw_rst_req, ch_rst_req, wr_en, rd_en, rd_ctl;
  logic [3:0] addr;
  logic [7:0] wdata, rdata, enh_sync;
  logic       rx_avail, rx_pop;
  logic [1:0] pll_miss_in;
  logic       rx_en, pll_active, pll_src_pin, pll_fm, brg_en, cfg_warn;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sccr_chan_regs i_sccr_chan_regs (
    .clk(clk), .rst_n(rst_n), .hw_rst_req(hw_rst_req), .ch_rst_req(ch_rst_req),
    .wr_en(wr_en), .rd_en(rd_en), .rd_ctl(rd_ctl), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_avail(rx_avail), .rx_pop(rx_pop), .pll_miss_in(pll_miss_in),
    .rx_en(rx_en), .pll_active(pll_active), .pll_src_pin(pll_src_pin), .pll_fm(pll_fm),
    .brg_en(brg_en), .enh_sync(enh_sync), .cfg_warn(cfg_warn)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hw_rst_req = 1'b0; ch_rst_req = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    rd_ctl = 1'b0; addr = '0; wdata = '0; rx_avail = 1'b0; rx_pop = 1'b0; pll_miss_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic ctl, input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_ctl = ctl; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0; rd_ctl = 1'b0;
  endtask

  task automatic pulse_rst(input logic hw);
    @(negedge clk);
    if (hw) hw_rst_req = 1'b1; else ch_rst_req = 1'b1;
    @(negedge clk);
    hw_rst_req = 1'b0; ch_rst_req = 1'b0;
  endtask

  task automatic t_por();
    logic [7:0] v;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = (i == 4) ? 8'h04 : (i == 11) ? 8'h08 : (i == 14) ? 8'h20 : (i == 15) ? 8'hF8 : 8'h00;
      rd(1'b1, 4'(i), v); chk("R1", $sformatf("por ctl%0d", i), v, e);
    end
    rd(1'b0, 4'd0, v);  chk("R3", "por st0", v, 8'h44);
    rd(1'b0, 4'd1, v);  chk("R3", "por st1", v, 8'h06);
    rd(1'b0, 4'd10, v); chk("R3", "por st10", v, 8'h00);
    chk("R3", "por outs", {2'b0, rx_en, pll_active, pll_src_pin, pll_fm, brg_en, cfg_warn}, 8'h00);
    chk("R6", "por enh", enh_sync, 8'h00);
  endtask

  task automatic t_plain();
    logic [7:0] v;
    logic [3:0] idx [7] = '{4'd0, 4'd2, 4'd6, 4'd8, 4'd9, 4'd12, 4'd13};
    do_reset();
    foreach (idx[k]) wr(idx[k], 8'h3C ^ {idx[k], 4'hA});
    foreach (idx[k]) begin
      rd(1'b1, idx[k], v); chk("R11", $sformatf("store ctl%0d", idx[k]), v, 8'h3C ^ {idx[k], 4'hA});
    end
    rd(1'b0, 4'd5, v); chk("R11", "unmapped status", v, 8'h00);
  endtask

  task automatic t_resets();
    logic [7:0] v;
    do_reset();
    wr(4'd1, 8'hFF); wr(4'd4, 8'h00); wr(4'd5, 8'hFF); wr(4'd10, 8'hFF);
    wr(4'd11, 8'hAB); wr(4'd12, 8'h5C); wr(4'd14, 8'hFF);
    chk("R8", "brg on", brg_en, 1);
    pulse_rst(1'b0);
    rd(1'b1, 4'd1, v);  chk("R2", "ch ctl1", v, 8'h24);
    rd(1'b1, 4'd4, v);  chk("R2", "ch ctl4", v, 8'h04);
    rd(1'b1, 4'd5, v);  chk("R2", "ch ctl5", v, 8'h61);
    rd(1'b1, 4'd10, v); chk("R2", "ch ctl10", v, 8'h60);
    rd(1'b1, 4'd11, v); chk("R2", "ch ctl11", v, 8'hAB);
    rd(1'b1, 4'd14, v); chk("R2", "ch ctl14", v, 8'hE3);
    rd(1'b1, 4'd12, v); chk("R2", "ch ctl12", v, 8'h5C);
    chk("R3", "ch brg off", brg_en, 0);
    pulse_rst(1'b1);
    rd(1'b1, 4'd10, v); chk("R1", "hw ctl10", v, 8'h00);
    rd(1'b1, 4'd11, v); chk("R1", "hw ctl11", v, 8'h08);
    rd(1'b1, 4'd14, v); chk("R1", "hw ctl14", v, 8'hE0);
    rd(1'b1, 4'd12, v); chk("R1", "hw ctl12", v, 8'h5C);
  endtask

  task automatic t_rxcfg();
    logic [7:0] v;
    do_reset();
    wr(4'd3, 8'h10);
    rd(1'b1, 4'd3, v); chk("R4", "hunt toggle ctl3", v, 8'h10);
    rd(1'b0, 4'd0, v); chk("R4", "hunt st0", v, 8'h54);
    wr(4'd3, 8'h00);
    rd(1'b1, 4'd3, v); chk("R4", "hunt sticky", v, 8'h10);
    do_reset();
    wr(4'd3, 8'hC1);
    rd(1'b1, 4'd3, v); chk("R5", "rx on ctl3", v, 8'hC1);
    chk("R5", "rx_en on", rx_en, 1);
    rd(1'b0, 4'd0, v); chk("R5", "no hunt st0", v, 8'h44);
    wr(4'd3, 8'hC0);
    rd(1'b1, 4'd3, v); chk("R5", "rx off ctl3", v, 8'hD0);
    chk("R5", "rx_en off", rx_en, 0);
    rd(1'b0, 4'd0, v); chk("R5", "rx off st0", v, 8'h54);
    wr(4'd3, 8'h2F);
    chk("R5", "rx_en again", rx_en, 1);
    rx_avail = 1'b1;
    rd(1'b0, 4'd0, v);
    rx_avail = 1'b0;
    pulse_rst(1'b0);
    rd(1'b0, 4'd0, v); chk("R3", "ch st0 mask", v, 8'h54);
    rd(1'b1, 4'd3, v); chk("R3", "ch ctl3", v, 8'h3E);
    chk("R3", "ch rx_en", rx_en, 0);
  endtask

  task automatic t_shadow();
    logic [7:0] v;
    do_reset();
    wr(4'd7, 8'h5A);
    rd(1'b1, 4'd7, v); chk("R6", "plain ctl7", v, 8'h5A);
    chk("R6", "enh idle", enh_sync, 8'h00);
    wr(4'd15, 8'hF9);
    wr(4'd7, 8'h3C);
    rd(1'b1, 4'd7, v); chk("R6", "ctl7 kept", v, 8'h5A);
    chk("R6", "enh loaded", enh_sync, 8'h3C);
  endtask

  task automatic t_pll();
    logic [7:0] v;
    do_reset();
    wr(4'd14, 8'h20); chk("R7", "search active", pll_active, 1);
    @(negedge clk); pll_miss_in = 2'b11;
    @(negedge clk); pll_miss_in = 2'b00;
    rd(1'b0, 4'd10, v); chk("R12", "miss set", v, 8'hC0);
    wr(4'd14, 8'h40);
    rd(1'b0, 4'd10, v); chk("R12", "miss clr cmd2", v, 8'h00);
    chk("R7", "cmd2 keeps active", pll_active, 1);
    wr(4'd14, 8'hA0); chk("R7", "src pin", pll_src_pin, 1);
    wr(4'd14, 8'hC0); chk("R7", "fm", pll_fm, 1);
    wr(4'd14, 8'hE0); chk("R7", "nrzi", pll_fm, 0);
    wr(4'd14, 8'h60);
    chk("R7", "off inactive", pll_active, 0);
    chk("R7", "off src brg", pll_src_pin, 0);
    wr(4'd14, 8'hA0); wr(4'd14, 8'h80); chk("R7", "src brg", pll_src_pin, 0);
    rd(1'b1, 4'd14, v); chk("R11", "ctl14 stored", v, 8'h80);
    @(negedge clk); pll_miss_in = 2'b10; wr_en = 1'b1; addr = 4'd14; wdata = 8'h20;
    @(negedge clk); pll_miss_in = 2'b00; wr_en = 1'b0;
    rd(1'b0, 4'd10, v); chk("R12", "clear wins", v, 8'h00);
    chk("R7", "search again", pll_active, 1);
  endtask

  task automatic t_brg_warn();
    do_reset();
    wr(4'd14, 8'h01);
    chk("R8", "brg set", brg_en, 1);
    chk("R9", "no warn", cfg_warn, 0);
    wr(4'd14, 8'h10);
    chk("R8", "brg clear", brg_en, 0);
    chk("R9", "warn pulse", cfg_warn, 1);
    @(negedge clk);
    chk("R9", "warn ends", cfg_warn, 0);
    wr(4'd14, 8'h04);
    chk("R9", "warn req bit", cfg_warn, 1);
  endtask

  task automatic t_rxavail();
    logic [7:0] v;
    do_reset();
    @(negedge clk); rx_avail = 1'b1;
    repeat (2) @(negedge clk); rx_avail = 1'b0;
    rd(1'b0, 4'd0, v); chk("R10", "no read no set", v, 8'h44);
    rx_avail = 1'b1;
    rd(1'b0, 4'd0, v); chk("R10", "read shows avail", v, 8'h45);
    rx_avail = 1'b0;
    rd(1'b0, 4'd0, v); chk("R10", "stored avail", v, 8'h45);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    rd(1'b0, 4'd0, v); chk("R10", "pop clears", v, 8'h44);
  endtask

  initial begin
    t_por();
    t_plain();
    t_resets();
    t_rxcfg();
    t_shadow();
    t_pll();
    t_brg_warn();
    t_rxavail();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule